// File: doc/BRIEF.md
# SCSI Initiator Command and Arbitration Controller

This block holds the initiator-side command state for a parallel SCSI bus, together with a monitor that watches the bus for arbitration. Software reaches it through a small synchronous register port with four locations: an output data byte, the command register, a mode register and a read-only status byte. From the stored command bits the block produces active-high assert strobes for the bus reset, ACK, BSY, SEL and ATN lines, and an output-enable for the data bus. The strobes are inverted to active-low and given open-drain drivers outside the block.

The live bus BSY and SEL lines pass through a two-flop synchroniser. The bus counts as free once both have been released for a parameterised number of consecutive clocks. When the mode register's arbitrate bit is set and the bus is free, the block drives BSY and puts the output data byte (the device ID) on the data bus. It then reports that arbitration is in progress. If some other device raises SEL while the block is arbitrating, the block stops driving, flags the loss and raises its interrupt.

Setting the bus-reset command bit drives the bus reset line and holds all other internal state cleared. Only the interrupt latch and the reset bit itself are kept. The interrupt latch is cleared only by a read of the status location.

Top module: `scsi_init_ctl`

## Requirements
- R1: After `rst_n` is low, every bus strobe, `dbus_o` and `irq_o` are 0, and locations 0, 1 and 2 read 0x00.
- R2: Location 0 (output data) and location 2 (mode) read back the last byte written. In the command register at location 1, bits 7,4,3,2,1,0 read back the last value written, and writes to bits 6 and 5 have no effect.
- R3: `rst_o` equals command bit 7. While that bit is 1, locations 0 and 2 and command bits 4..0 read 0, writes to them are ignored, and `irq_o` is 1 from the following clock onwards. An external `rst_n` clears the bit.
- R4: The interrupt latch stays set after command bit 7 is cleared. It clears only at the clock edge on which location 3 is read. Status bits: 7 interrupt, 6 bus free, 1 synchronised BSY, 0 synchronised SEL, all others 0.
- R5: `ack_o` is command bit 4 ANDed with the inverse of mode bit 6 (target mode).
- R6: `bsy_o`, `sel_o`, `atn_o` and `dbus_oe_o` follow command bits 3, 2, 1 and 0 respectively. `dbus_o` always carries the output data byte.
- R7: Status bit 6 reads 1 after `bus_bsy_i` and `bus_sel_i` have both been low for `FREE_CYC` synchronised clocks. It reads 0 within three clocks of either input going high.
- R8: Command bit 6 (arbitration in progress) can only rise while mode bit 0 is 1 and the bus is free. When it rises, `bsy_o` and `dbus_oe_o` are asserted with `dbus_o` equal to the output data byte. It stays 0 while mode bit 0 is 0.
- R9: Once set, command bit 6 stays 1 while mode bit 0 is 1, whatever the bus lines do afterwards.
- R10: If synchronised SEL is seen during arbitration while command bit 2 is 0, command bit 5 (lost) becomes 1. The block then stops driving BSY and the data bus, and `irq_o` is set.
- R11: Clearing mode bit 0 returns command bits 6 and 5 to 0 within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the interrupt on status reads) |
| reg_addr | input | 2 | Register location: 0 data, 1 command, 2 mode, 3 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed location |
| bus_bsy_i | input | 1 | Live bus BSY, 1 = asserted |
| bus_sel_i | input | 1 | Live bus SEL, 1 = asserted |
| rst_o | output | 1 | Assert bus reset |
| ack_o | output | 1 | Assert ACK |
| bsy_o | output | 1 | Assert BSY |
| sel_o | output | 1 | Assert SEL |
| atn_o | output | 1 | Assert ATN |
| dbus_oe_o | output | 1 | Drive the data bus |
| dbus_o | output | 8 | Data bus value |
| irq_o | output | 1 | Interrupt request |

## Verification
The arbitration state machine is visible only through command bits 6 and 5 and the drive strobes. A state left stuck in arbitrating or lost shows up at once as a wrong command readback or as `bsy_o` staying set after the arbitrate bit is cleared. A bus-free counter that is wrong shows in status bit 6 and in arbitration starting early or late. The bench samples that bit at fixed distances from input changes, so an off-by-one in the synchroniser or the counter shows as a read of the wrong value. A hold-clear that misses a register surfaces on the next readback or on `dbus_o` while the bus reset is set. A broken interrupt latch shows on `irq_o` within one clock of the status read.

// File: rtl/scsi_ic_pkg.sv
// Shared constants and types for the SCSI initiator command controller.
// Bit positions are fixed by the software-visible register layout.
package scsi_ic_pkg;

    localparam int REG_DW = 8;
    localparam int REG_AW = 2;

    localparam logic [REG_AW-1:0] LOC_ODR  = 2'd0;
    localparam logic [REG_AW-1:0] LOC_CMD  = 2'd1;
    localparam logic [REG_AW-1:0] LOC_MODE = 2'd2;
    localparam logic [REG_AW-1:0] LOC_STAT = 2'd3;

    // command register bit positions
    localparam int CB_RST = 7;
    localparam int CB_AIP = 6;
    localparam int CB_LA  = 5;
    localparam int CB_ACK = 4;
    localparam int CB_BSY = 3;
    localparam int CB_SEL = 2;
    localparam int CB_ATN = 1;
    localparam int CB_DBE = 0;

    // mode register bit positions
    localparam int MB_ARB = 0;
    localparam int MB_TGT = 6;

    // status register bit positions
    localparam int SB_IRQ  = 7;
    localparam int SB_FREE = 6;
    localparam int SB_BSY  = 1;
    localparam int SB_SEL  = 0;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_OWN  = 2'd1,
        ARB_LOST = 2'd2
    } arb_st_e;

    typedef struct packed {
        logic rst;
        logic ack;
        logic bsy;
        logic sel;
        logic atn;
        logic dbe;
    } cmd_bits_t;

endpackage

// File: rtl/scsi_ic_sync.sv
// Multi-stage flip-flop synchroniser for asynchronous bus inputs.
// Assumes each bit is an independent level; no bus coherency is kept.
module scsi_ic_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= d;
            end
        end else begin : g_next
            // later stages resolve metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/scsi_ic_busfree.sv
// Bus-free detector: counts consecutive clocks with synchronised BSY and
// SEL both released and saturates at FREE_CYC. Assumes inputs are
// already synchronised. clr holds the count at zero.
module scsi_ic_busfree #(
    parameter int FREE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bsy_s,
    input  logic sel_s,
    output logic bus_free
);

    localparam int CW = $clog2(FREE_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(FREE_CYC);

    logic [CW-1:0] idle_cnt;

    // count idle clocks, restart on any activity
    always_ff @(posedge clk) begin
        if (!rst_n || clr)             idle_cnt <= '0;
        else if (bsy_s || sel_s)       idle_cnt <= '0;
        else if (idle_cnt != CNT_MAX)  idle_cnt <= idle_cnt + 1'b1;
    end

    assign bus_free = (idle_cnt == CNT_MAX);

endmodule

// File: rtl/scsi_ic_arb.sv
// Arbitration monitor. Leaves idle when arbitration is enabled and the bus
// is free, then drives BSY and the ID. It falls to lost when another device
// raises SEL (SEL not from this block's own command bit). It returns to idle
// only when arbitration is disabled or the bus-reset hold is active.
module scsi_ic_arb
    import scsi_ic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arb_en,
    input  logic bus_free,
    input  logic sel_s,
    input  logic own_sel,
    output logic aip,
    output logic lost,
    output logic drive,
    output logic lost_evt
);

    arb_st_e st_q, st_d;

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE: if (arb_en && bus_free)  st_d = ARB_OWN;
            ARB_OWN: begin
                if (!arb_en)                   st_d = ARB_IDLE;
                else if (sel_s && !own_sel)    st_d = ARB_LOST;
            end
            ARB_LOST: if (!arb_en)             st_d = ARB_IDLE;
            default:                           st_d = ARB_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || clr) st_q <= ARB_IDLE;
        else               st_q <= st_d;
    end

    assign aip      = (st_q != ARB_IDLE);
    assign lost     = (st_q == ARB_LOST);
    assign drive    = (st_q == ARB_OWN);
    assign lost_evt = (st_q == ARB_OWN) && (st_d == ARB_LOST) && !clr;

endmodule

// File: rtl/scsi_ic_regs.sv
// Software register file: output data, command and mode storage, the
// interrupt latch and the read multiplexer. The bus-reset bit, once set,
// holds every other stored bit clear. hold_o shares that hold with the
// other sub-blocks. The latch clears only on a read of the status location.
module scsi_ic_regs
    import scsi_ic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic              aip,
    input  logic              lost,
    input  logic              lost_evt,
    input  logic              bus_free,
    input  logic              bsy_s,
    input  logic              sel_s,
    output logic [REG_DW-1:0] reg_rdata,
    output logic [REG_DW-1:0] odr_q,
    output logic [REG_DW-1:0] mode_q,
    output cmd_bits_t         cmd_q,
    output logic              hold_o,
    output logic              irq_q
);

    logic wr_odr, wr_cmd, wr_mode, rd_stat;
    logic rst_d;

    assign wr_odr  = reg_wr && (reg_addr == LOC_ODR);
    assign wr_cmd  = reg_wr && (reg_addr == LOC_CMD);
    assign wr_mode = reg_wr && (reg_addr == LOC_MODE);
    assign rd_stat = reg_rd && (reg_addr == LOC_STAT);

    // next value of the bus-reset bit; other state is cleared when it is 1
    assign rst_d  = wr_cmd ? reg_wdata[CB_RST] : cmd_q.rst;
    assign hold_o = rst_d;

    // bus-reset bit, cleared only by chip reset or a software write
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q.rst <= 1'b0;
        else        cmd_q.rst <= rst_d;
    end

    // writable command bits other than bus reset
    always_ff @(posedge clk) begin
        if (!rst_n || rst_d) begin
            cmd_q.ack <= 1'b0;
            cmd_q.bsy <= 1'b0;
            cmd_q.sel <= 1'b0;
            cmd_q.atn <= 1'b0;
            cmd_q.dbe <= 1'b0;
        end else if (wr_cmd) begin
            cmd_q.ack <= reg_wdata[CB_ACK];
            cmd_q.bsy <= reg_wdata[CB_BSY];
            cmd_q.sel <= reg_wdata[CB_SEL];
            cmd_q.atn <= reg_wdata[CB_ATN];
            cmd_q.dbe <= reg_wdata[CB_DBE];
        end
    end

    // output data register
    always_ff @(posedge clk) begin
        if (!rst_n || rst_d) odr_q <= '0;
        else if (wr_odr)     odr_q <= reg_wdata;
    end

    // mode register
    always_ff @(posedge clk) begin
        if (!rst_n || rst_d) mode_q <= '0;
        else if (wr_mode)    mode_q <= reg_wdata;
    end

    // interrupt latch: set by bus reset or lost arbitration, cleared on status read
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (irq_q && !rd_stat) || cmd_q.rst || lost_evt;
    end

    // read multiplexer
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            LOC_ODR:  reg_rdata = odr_q;
            LOC_MODE: reg_rdata = mode_q;
            LOC_CMD: begin
                reg_rdata[CB_RST] = cmd_q.rst;
                reg_rdata[CB_AIP] = aip;
                reg_rdata[CB_LA]  = lost;
                reg_rdata[CB_ACK] = cmd_q.ack;
                reg_rdata[CB_BSY] = cmd_q.bsy;
                reg_rdata[CB_SEL] = cmd_q.sel;
                reg_rdata[CB_ATN] = cmd_q.atn;
                reg_rdata[CB_DBE] = cmd_q.dbe;
            end
            LOC_STAT: begin
                reg_rdata[SB_IRQ]  = irq_q;
                reg_rdata[SB_FREE] = bus_free;
                reg_rdata[SB_BSY]  = bsy_s;
                reg_rdata[SB_SEL]  = sel_s;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/scsi_init_ctl.sv
// Top of the SCSI initiator command and arbitration controller. It ties the
// register file, the input synchroniser, the bus-free detector and the
// arbitration monitor together and forms the active-high bus strobes.
// Assumes the pads invert the strobes and provide open-drain drive.
module scsi_init_ctl
    import scsi_ic_pkg::*;
#(
    parameter int FREE_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              bus_bsy_i,
    input  logic              bus_sel_i,
    output logic              rst_o,
    output logic              ack_o,
    output logic              bsy_o,
    output logic              sel_o,
    output logic              atn_o,
    output logic              dbus_oe_o,
    output logic [REG_DW-1:0] dbus_o,
    output logic              irq_o
);

    logic [REG_DW-1:0] odr_q;
    logic [REG_DW-1:0] mode_q;
    cmd_bits_t         cmd_q;
    logic              hold;
    logic              irq_q;
    logic [1:0]        bus_s;
    logic              bsy_s, sel_s;
    logic              bus_free;
    logic              aip, lost, drive, lost_evt;

    scsi_ic_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_bsy_i, bus_sel_i}),
        .q     (bus_s)
    );

    assign bsy_s = bus_s[1];
    assign sel_s = bus_s[0];

    scsi_ic_busfree #(.FREE_CYC(FREE_CYC)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold),
        .bsy_s    (bsy_s),
        .sel_s    (sel_s),
        .bus_free (bus_free)
    );

    scsi_ic_arb u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (hold),
        .arb_en   (mode_q[MB_ARB]),
        .bus_free (bus_free),
        .sel_s    (sel_s),
        .own_sel  (cmd_q.sel),
        .aip      (aip),
        .lost     (lost),
        .drive    (drive),
        .lost_evt (lost_evt)
    );

    scsi_ic_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .aip       (aip),
        .lost      (lost),
        .lost_evt  (lost_evt),
        .bus_free  (bus_free),
        .bsy_s     (bsy_s),
        .sel_s     (sel_s),
        .reg_rdata (reg_rdata),
        .odr_q     (odr_q),
        .mode_q    (mode_q),
        .cmd_q     (cmd_q),
        .hold_o    (hold),
        .irq_q     (irq_q)
    );

    assign rst_o     = cmd_q.rst;
    assign ack_o     = cmd_q.ack && !mode_q[MB_TGT];
    assign bsy_o     = cmd_q.bsy || drive;
    assign sel_o     = cmd_q.sel;
    assign atn_o     = cmd_q.atn;
    assign dbus_oe_o = cmd_q.dbe || drive;
    assign dbus_o    = odr_q;
    assign irq_o     = irq_q;

endmodule

// File: rtl/scsi_init_ctl_chk.sv
// Property checker for scsi_init_ctl, bound to every instance. It observes
// ports and internal state and drives nothing.
module scsi_init_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_o,
    input logic       ack_o,
    input logic       irq_o,
    input logic [7:0] odr_q,
    input logic [7:0] mode_q,
    input logic       aip,
    input logic       lost,
    input logic       drive,
    input logic       bus_free,
    input logic       sel_s,
    input logic       own_sel
);

    // R5
    ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !mode_q[6]);

    // R3
    bus_rst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> irq_o);

    // R3
    bus_rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> (odr_q == 8'h00 && mode_q == 8'h00 && !aip));

    // R8
    aip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aip) |-> $past(bus_free && mode_q[0]));

    // R8
    aip_needs_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aip |-> (mode_q[0] || $past(mode_q[0])));

    // R10
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> !drive);

    // R10
    lost_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(sel_s && !own_sel));

    // R11
    arb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q[0] && !$past(mode_q[0])) |-> (!aip && !lost));

endmodule

bind scsi_init_ctl scsi_init_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_o    (rst_o),
    .ack_o    (ack_o),
    .irq_o    (irq_o),
    .odr_q    (odr_q),
    .mode_q   (mode_q),
    .aip      (aip),
    .lost     (lost),
    .drive    (drive),
    .bus_free (bus_free),
    .sel_s    (sel_s),
    .own_sel  (cmd_q.sel)
);

// File: tb/scsi_init_ctl_tb.sv
// Self-checking bench for scsi_init_ctl: a vector table for register and
// strobe behaviour, then directed tests for reset, bus-free and arbitration.
module scsi_init_ctl_tb;

    localparam int FREE_CYC = 8;
    localparam int NVEC     = 21;
    localparam int WDOG     = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       bus_bsy_i = 1'b1;
    logic       bus_sel_i = 1'b0;
    logic       rst_o, ack_o, bsy_o, sel_o, atn_o, dbus_oe_o, irq_o;
    logic [7:0] dbus_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scsi_init_ctl #(.FREE_CYC(FREE_CYC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .bus_bsy_i (bus_bsy_i),
        .bus_sel_i (bus_sel_i),
        .rst_o     (rst_o),
        .ack_o     (ack_o),
        .bsy_o     (bsy_o),
        .sel_o     (sel_o),
        .atn_o     (atn_o),
        .dbus_oe_o (dbus_oe_o),
        .dbus_o    (dbus_o),
        .irq_o     (irq_o)
    );

    // vector: {is_write, addr[1:0], wdata[7:0], exp_rdata[7:0], exp_out[5:0]}
    // exp_out = {rst_o, ack_o, bsy_o, sel_o, atn_o, dbus_oe_o}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 8'hA5, 8'h00, 6'h00},  // R2 write data
        {1'b0, 2'd0, 8'h00, 8'hA5, 6'h00},  // R2 read data
        {1'b1, 2'd2, 8'h40, 8'h00, 6'h00},  // R2 target mode
        {1'b0, 2'd2, 8'h00, 8'h40, 6'h00},  // R2 read mode
        {1'b1, 2'd1, 8'h1F, 8'h00, 6'h0F},  // R5 ack blocked, R6 strobes
        {1'b0, 2'd1, 8'h00, 8'h1F, 6'h0F},  // R2 read command
        {1'b1, 2'd2, 8'h00, 8'h00, 6'h1F},  // R5 ack released
        {1'b1, 2'd1, 8'h7A, 8'h00, 6'h1A},  // R2 bits 6,5 ignored
        {1'b0, 2'd1, 8'h00, 8'h1A, 6'h1A},  // R2 readback
        {1'b1, 2'd1, 8'h00, 8'h00, 6'h00},  // R6 all released
        {1'b0, 2'd3, 8'h00, 8'h02, 6'h00},  // R4 status layout
        {1'b1, 2'd1, 8'h80, 8'h00, 6'h20},  // R3 bus reset
        {1'b0, 2'd0, 8'h00, 8'h00, 6'h20},  // R3 data cleared
        {1'b0, 2'd2, 8'h00, 8'h00, 6'h20},  // R3 mode cleared
        {1'b1, 2'd0, 8'h33, 8'h00, 6'h20},  // R3 write ignored
        {1'b0, 2'd0, 8'h00, 8'h00, 6'h20},  // R3 still cleared
        {1'b0, 2'd1, 8'h00, 8'h80, 6'h20},  // R3 bit 7 reads back
        {1'b0, 2'd3, 8'h00, 8'h82, 6'h20},  // R3 irq set
        {1'b1, 2'd1, 8'h00, 8'h00, 6'h00},  // R3 release
        {1'b0, 2'd3, 8'h00, 8'h82, 6'h00},  // R4 latch survives
        {1'b0, 2'd3, 8'h00, 8'h02, 6'h00}   // R4 cleared by read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [5:0] outs();
        return {rst_o, ack_o, bsy_o, sel_o, atn_o, dbus_oe_o};
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (4) @(negedge clk);
        // R1 reset state, still in reset
        check("R1 outs", {26'd0, outs()}, 32'h0);
        check("R1 irq", {31'd0, irq_o}, 32'h0);
        check("R1 dbus", {24'd0, dbus_o}, 32'h0);
        rst_n = 1'b1;
        rd_reg(2'd0, rd); check("R1 data", {24'd0, rd}, 32'h00);
        rd_reg(2'd1, rd); check("R1 cmd",  {24'd0, rd}, 32'h00);
        rd_reg(2'd2, rd); check("R1 mode", {24'd0, rd}, 32'h00);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [24:0] v;
            v = VEC[i];
            if (v[24]) begin
                wr_reg(v[23:22], v[21:14]);
            end else begin
                rd_reg(v[23:22], rd);
                check($sformatf("R2-4 vec%0d rdata", i), {24'd0, rd}, {24'd0, v[13:6]});
            end
            check($sformatf("R3-6 vec%0d outs", i), {26'd0, outs()}, {26'd0, v[5:0]});
        end

        // R6 data bus mirrors the data register
        wr_reg(2'd0, 8'h5C);
        check("R6 dbus", {24'd0, dbus_o}, 32'h5C);

        // R7 bus free after idle period
        bus_bsy_i = 1'b0; bus_sel_i = 1'b0;
        repeat (FREE_CYC + 4) @(negedge clk);
        rd_reg(2'd3, rd); check("R7 free", {24'd0, rd}, 32'h40);

        // R8 no arbitration without arbitrate bit
        repeat (3) @(negedge clk);
        rd_reg(2'd1, rd); check("R8 no aip", {24'd0, rd}, 32'h00);
        check("R8 no drive", {30'd0, bsy_o, dbus_oe_o}, 32'h0);

        // R8 arbitration start
        wr_reg(2'd0, 8'h04);
        wr_reg(2'd2, 8'h01);
        rd_reg(2'd1, rd); check("R8 aip", {24'd0, rd}, 32'h40);
        check("R8 drive", {30'd0, bsy_o, dbus_oe_o}, 32'h3);
        check("R8 id", {24'd0, dbus_o}, 32'h04);

        // R9 aip holds as the bus shows busy; R7 free drops
        bus_bsy_i = 1'b1;
        repeat (6) @(negedge clk);
        rd_reg(2'd1, rd); check("R9 aip hold", {24'd0, rd}, 32'h40);
        rd_reg(2'd3, rd); check("R7 busy", {24'd0, rd}, 32'h02);

        // R10 another device selects
        bus_sel_i = 1'b1;
        repeat (5) @(negedge clk);
        rd_reg(2'd1, rd); check("R10 lost", {24'd0, rd}, 32'h60);
        check("R10 release", {30'd0, bsy_o, dbus_oe_o}, 32'h0);
        check("R10 irq", {31'd0, irq_o}, 32'h1);

        // R11 clearing arbitrate bit
        wr_reg(2'd2, 8'h00);
        rd_reg(2'd1, rd); check("R11 clear", {24'd0, rd}, 32'h00);
        rd_reg(2'd3, rd); check("R4 status", {24'd0, rd}, 32'h83);
        check("R4 irq cleared", {31'd0, irq_o}, 32'h0);

        // R3 chip reset clears the bus-reset bit
        wr_reg(2'd1, 8'h80);
        check("R3 rst_o", {31'd0, rst_o}, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R3 chip reset rst_o", {31'd0, rst_o}, 32'h0);
        check("R1 chip reset irq", {31'd0, irq_o}, 32'h0);
        rst_n = 1'b1;

        finish_run();
    end

endmodule